// File: doc/BRIEF.md
# Merging Store Buffer for a Write-Through Cache

This block sits between a write-through data cache and the next memory level and holds stores that have not yet been written out. It has a small number of entries. Each entry covers one aligned multi-word block and keeps a valid bit for every word in it. Most stores write a single word. When merging is enabled, a store whose block is already pending in an entry that is not yet being written out goes into that entry's word slot. Any other store takes a free entry. The processor side is stalled only when every entry is occupied and the store cannot merge.

Entries are written to memory one at a time, oldest first. The memory port presents a block-aligned address, the full block of data and a word mask. It holds these steady until memory acknowledges, and the entry is released on that acknowledge. Once an entry's write request has been raised, that entry is closed to merging, and a later store to the same block opens a new entry.

A read miss presents its address to the buffer. If any pending entry holds that word, the block forwards the newest pending value so that the read never returns stale memory data. If no entry holds the word, the read may go to memory ahead of the queued writes.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset the buffer is empty. `mem_req`, `st_stall` and `rd_fwd` are low, and the first store is accepted.
- R2: A store's block address is its address with the low four bits cleared. Address bits [3:2] select the 32-bit word slot (0..3) and bits [1:0] are ignored. `mem_addr` has its low four bits at zero, and `mem_mask` bit w is set exactly when word w of the draining entry holds a pending store.
- R3: With `merge_en`=1, a store to the block of a pending entry whose write request has not yet been raised goes into that entry. It sets the word's mask bit and takes no new entry. If several such entries exist, the newest one receives the store.
- R4: With `merge_en`=0, or when no open entry matches, an accepted store takes a new entry whose mask has only that word set.
- R5: `st_stall` is high exactly when `st_valid` is high, all four entries are occupied and the store does not merge. A stalled store changes no entry.
- R6: Entries drain oldest first. `mem_req` rises one cycle after the buffer becomes non-empty while idle. Address, data and mask stay stable until `mem_ack`. The entry is freed at that edge, and `mem_req` is low for one cycle before the next entry is offered.
- R7: Once `mem_req` is high for an entry, a store to that entry's block does not merge into it and takes a new entry.
- R8: When `rd_valid` is high and some pending entry holds the addressed word, `rd_fwd` is high and `rd_data` equals that word from the newest such entry.
- R9: When no pending entry holds the addressed word, including when only other words of its block are pending, `rd_fwd` is low.
- R10: A later store to a word that is already pending in an open entry overwrites it, and the entry drains with the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request from the cache side |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store word |
| merge_en | input | 1 | Allow merging into an open entry |
| st_stall | output | 1 | Store not accepted this cycle |
| rd_valid | input | 1 | Read-miss lookup request |
| rd_addr | input | ADDR_W | Read-miss byte address |
| rd_fwd | output | 1 | Addressed word is pending; use rd_data |
| rd_data | output | DATA_W | Newest pending value of the word |
| mem_req | output | 1 | Drain write request |
| mem_addr | output | ADDR_W | Block-aligned drain address |
| mem_data | output | BLOCK_WORDS*DATA_W | Drain block, word w at bits [32w+31:32w] |
| mem_mask | output | BLOCK_WORDS | Words of the block to write |
| mem_ack | input | 1 | Memory accepts the drain write |

## Verification
The bound checker checks these properties on every cycle: the drain request holds a stable address, data and nonzero mask until it is acknowledged, and it drops for a cycle after each acknowledge. The occupancy count moves by exactly one for each allocation or release and never exceeds the depth. A stall appears only when the buffer is full, and forwarding appears only on a read request. The bench's scenarios and sweep show the rest: which entry a store merges into, that a write request closes an entry, the drain order, the last-value-wins content of drained blocks, and which of several pending copies a read-miss forwards. An independent queue model checks these against the ports on every cycle.

// File: rtl/wb_pkg.sv
package wb_pkg;

  typedef enum logic {
    DRAIN_IDLE = 1'b0,
    DRAIN_WAIT = 1'b1
  } drain_st_e;

  // slot that lies k places after base on a ring of n slots
  function automatic int unsigned ring_slot(input int unsigned base,
                                            input int unsigned k,
                                            input int unsigned n);
    return (base + k) % n;
  endfunction

  // next slot on a ring of n slots
  function automatic int unsigned ring_next(input int unsigned p,
                                            input int unsigned n);
    return (p + 1 == n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/wb_entry.sv
module wb_entry #(
  parameter int TAG_W  = 28,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int WIDX_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_i,
  input  logic                          merge_i,
  input  logic                          free_i,
  input  logic [TAG_W-1:0]              tag_i,
  input  logic [WIDX_W-1:0]             widx_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic                          valid_o,
  output logic [TAG_W-1:0]              tag_o,
  output logic [WORDS-1:0]              mask_o,
  output logic [WORDS-1:0][DATA_W-1:0]  data_o
);

  logic [WORDS-1:0] word_onehot;
  assign word_onehot = WORDS'(1) << widx_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      mask_o  <= '0;
      data_o  <= '0;
    end else begin
      if (free_i) begin
        valid_o <= 1'b0;
      end
      if (alloc_i) begin
        valid_o <= 1'b1;
        tag_o   <= tag_i;
        mask_o  <= word_onehot;
      end else if (merge_i) begin
        mask_o  <= mask_o | word_onehot;
      end
      if (alloc_i || merge_i) begin
        data_o[widx_i] <= data_i;
      end
    end
  end

endmodule

// File: rtl/wb_lookup.sv
module wb_lookup #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 28,
  parameter int PTR_W = 2
) (
  input  logic [DEPTH-1:0]             qual_i,
  input  logic [DEPTH-1:0][TAG_W-1:0]  tags_i,
  input  logic [PTR_W-1:0]             head_i,
  input  logic [TAG_W-1:0]             key_i,
  output logic                         hit_o,
  output logic [PTR_W-1:0]             idx_o
);
  import wb_pkg::*;

  // scan from oldest to newest; the last match found is the newest
  always_comb begin
    hit_o = 1'b0;
    idx_o = head_i;
    for (int k = 0; k < DEPTH; k++) begin
      int unsigned s;
      s = ring_slot(int'(head_i), k, DEPTH);
      if (qual_i[s] && (tags_i[s] == key_i)) begin
        hit_o = 1'b1;
        idx_o = PTR_W'(s);
      end
    end
  end

endmodule

// File: rtl/wb_drain.sv
module wb_drain (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic ack_i,
  output logic req_o,
  output logic done_o
);
  import wb_pkg::*;

  drain_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= DRAIN_IDLE;
    end else begin
      unique case (st_q)
        DRAIN_IDLE: if (pending_i) st_q <= DRAIN_WAIT;
        DRAIN_WAIT: if (ack_i)     st_q <= DRAIN_IDLE;
        default:                   st_q <= DRAIN_IDLE;
      endcase
    end
  end

  assign req_o  = (st_q == DRAIN_WAIT);
  assign done_o = req_o & ack_i;

endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BLOCK_WORDS = 4,
  parameter int DEPTH       = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          st_valid,
  input  logic [ADDR_W-1:0]             st_addr,
  input  logic [DATA_W-1:0]             st_data,
  input  logic                          merge_en,
  output logic                          st_stall,
  input  logic                          rd_valid,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic                          rd_fwd,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          mem_req,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [BLOCK_WORDS*DATA_W-1:0] mem_data,
  output logic [BLOCK_WORDS-1:0]        mem_mask,
  input  logic                          mem_ack
);
  import wb_pkg::*;

  localparam int BYTE_OFF = $clog2(DATA_W / 8);
  localparam int WIDX_W   = $clog2(BLOCK_WORDS);
  localparam int BLK_OFF  = BYTE_OFF + WIDX_W;
  localparam int TAG_W    = ADDR_W - BLK_OFF;
  localparam int PTR_W    = $clog2(DEPTH);
  localparam int CNT_W    = $clog2(DEPTH + 1);

  function automatic logic [TAG_W-1:0] blk_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BLK_OFF];
  endfunction

  function automatic logic [WIDX_W-1:0] word_sel(input logic [ADDR_W-1:0] a);
    return a[BLK_OFF-1:BYTE_OFF];
  endfunction

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return PTR_W'(ring_next(int'(p), DEPTH));
  endfunction

  // entry state
  logic [DEPTH-1:0]                               ent_valid;
  logic [DEPTH-1:0][TAG_W-1:0]                    ent_tag;
  logic [DEPTH-1:0][BLOCK_WORDS-1:0]              ent_mask;
  logic [DEPTH-1:0][BLOCK_WORDS-1:0][DATA_W-1:0]  ent_data;

  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;

  // decoded request fields
  logic [TAG_W-1:0]  st_tag, rd_tag;
  logic [WIDX_W-1:0] st_widx, rd_widx;
  assign st_tag  = blk_tag(st_addr);
  assign st_widx = word_sel(st_addr);
  assign rd_tag  = blk_tag(rd_addr);
  assign rd_widx = word_sel(rd_addr);

  logic unused_byte_bits;
  assign unused_byte_bits = ^{st_addr[BYTE_OFF-1:0], rd_addr[BYTE_OFF-1:0]};

  // named events
  logic buf_full, ev_merge, ev_alloc, ev_stall, ev_drain, ev_fwd;
  logic drain_req;

  // an entry whose write request is raised is closed to merging
  logic [DEPTH-1:0] lock_vec, merge_qual, rd_qual;
  assign lock_vec   = drain_req ? (DEPTH'(1) << head) : '0;
  assign merge_qual = ent_valid & ~lock_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rdq
    assign rd_qual[g] = ent_valid[g] & ent_mask[g][rd_widx];
  end

  logic             mrg_hit, rd_hit;
  logic [PTR_W-1:0] mrg_idx, rd_idx;

  wb_lookup #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PTR_W(PTR_W)) u_merge_lookup (
    .qual_i (merge_qual),
    .tags_i (ent_tag),
    .head_i (head),
    .key_i  (st_tag),
    .hit_o  (mrg_hit),
    .idx_o  (mrg_idx)
  );

  wb_lookup #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PTR_W(PTR_W)) u_read_lookup (
    .qual_i (rd_qual),
    .tags_i (ent_tag),
    .head_i (head),
    .key_i  (rd_tag),
    .hit_o  (rd_hit),
    .idx_o  (rd_idx)
  );

  assign buf_full = (count == CNT_W'(DEPTH));
  assign ev_merge = st_valid & merge_en & mrg_hit;
  assign ev_alloc = st_valid & ~ev_merge & ~buf_full;
  assign ev_stall = st_valid & ~ev_merge & buf_full;
  assign ev_fwd   = rd_valid & rd_hit;

  wb_drain u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (count != '0),
    .ack_i     (mem_ack),
    .req_o     (drain_req),
    .done_o    (ev_drain)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    wb_entry #(
      .TAG_W  (TAG_W),
      .WORDS  (BLOCK_WORDS),
      .DATA_W (DATA_W),
      .WIDX_W (WIDX_W)
    ) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc_i (ev_alloc && (tail == PTR_W'(g))),
      .merge_i (ev_merge && (mrg_idx == PTR_W'(g))),
      .free_i  (ev_drain && (head == PTR_W'(g))),
      .tag_i   (st_tag),
      .widx_i  (st_widx),
      .data_i  (st_data),
      .valid_o (ent_valid[g]),
      .tag_o   (ent_tag[g]),
      .mask_o  (ent_mask[g]),
      .data_o  (ent_data[g])
    );
  end

  // ring pointers and occupancy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (ev_alloc) tail <= ptr_inc(tail);
      if (ev_drain) head <= ptr_inc(head);
      unique case ({ev_alloc, ev_drain})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // outputs
  assign st_stall = ev_stall;
  assign rd_fwd   = ev_fwd;
  assign rd_data  = ev_fwd ? ent_data[rd_idx][rd_widx] : '0;
  assign mem_req  = drain_req;
  assign mem_addr = {ent_tag[head], {BLK_OFF{1'b0}}};
  assign mem_data = ent_data[head];
  assign mem_mask = ent_mask[head];

endmodule

// File: rtl/wb_checker.sv
module wb_checker #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BLOCK_WORDS = 4,
  parameter int DEPTH       = 4,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int BLK_OFF    = $clog2(DATA_W / 8) + $clog2(BLOCK_WORDS)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          st_stall,
  input logic                          ev_merge,
  input logic                          ev_alloc,
  input logic                          ev_drain,
  input logic [CNT_W-1:0]              count,
  input logic                          rd_valid,
  input logic                          rd_fwd,
  input logic                          mem_req,
  input logic                          mem_ack,
  input logic [ADDR_W-1:0]             mem_addr,
  input logic [BLOCK_WORDS*DATA_W-1:0] mem_data,
  input logic [BLOCK_WORDS-1:0]        mem_mask
);

  // R1: occupancy never passes the depth
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R2: the drain address is block aligned
  a_r2_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[BLK_OFF-1:0] == '0));

  // R2: an offered entry always carries at least one word
  a_r2_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_mask != '0));

  // R4: an allocation without a release grows occupancy by one
  a_r4_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_alloc && !ev_drain) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R5: a stall only appears with every entry occupied
  a_r5_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |-> (count == CNT_W'(DEPTH)));

  // R5: a stalled store neither merges nor allocates
  a_r5_stall_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |-> (!ev_merge && !ev_alloc));

  // R6: the drain request holds its contents until acknowledged
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_data) && $stable(mem_mask)));

  // R6: request drops for one cycle after each acknowledge
  a_r6_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  // R6: a pending entry is offered on the next cycle when idle
  a_r6_req_rises: assert property (@(posedge clk) disable iff (!rst_n)
    ((count != '0) && !mem_req) |=> mem_req);

  // R6: a release without an allocation shrinks occupancy by one
  a_r6_release_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drain && !ev_alloc) |=> (count == CNT_W'($past(count) - 1'b1)));

  // R8: forwarding only answers a read request
  a_r8_fwd_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fwd |-> rd_valid);

endmodule

bind merge_write_buffer wb_checker #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .BLOCK_WORDS (BLOCK_WORDS),
  .DEPTH       (DEPTH)
) u_wb_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .st_stall (st_stall),
  .ev_merge (ev_merge),
  .ev_alloc (ev_alloc),
  .ev_drain (ev_drain),
  .count    (count),
  .rd_valid (rd_valid),
  .rd_fwd   (rd_fwd),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .mem_data (mem_data),
  .mem_mask (mem_mask)
);

// File: tb/tb_merge_write_buffer.sv
`timescale 1ns/1ps
module tb_merge_write_buffer;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid, merge_en, rd_valid, mem_ack;
  logic [31:0]  st_addr, st_data, rd_addr;
  logic         st_stall, rd_fwd, mem_req;
  logic [31:0]  rd_data, mem_addr;
  logic [127:0] mem_data;
  logic [3:0]   mem_mask;

  always #2.5 clk = ~clk;

  merge_write_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .merge_en(merge_en), .st_stall(st_stall),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_fwd(rd_fwd), .rd_data(rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_mask(mem_mask), .mem_ack(mem_ack)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  string cur_tag = "R2";

  // reference queue, index 0 is the oldest entry
  int          q_n = 0;
  logic [27:0] q_tag [4];
  logic [3:0]  q_mask [4];
  logic [31:0] q_dat [4][4];
  bit          m_req = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int blk, input int w, input int bt);
    return (32'(blk) << 4) | (32'(w) << 2) | 32'(bt & 3);
  endfunction

  function automatic int find_merge(input logic [27:0] t);
    for (int i = q_n - 1; i >= (m_req ? 1 : 0); i--)
      if (q_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int find_word(input logic [27:0] t, input int w);
    for (int i = q_n - 1; i >= 0; i--)
      if (q_tag[i] == t && q_mask[i][w]) return i;
    return -1;
  endfunction

  task automatic drive(input logic sv, input logic [31:0] sa, input logic [31:0] sd,
                       input logic me, input logic rv, input logic [31:0] ra,
                       input logic ack);
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; merge_en = me;
    rd_valid = rv; rd_addr = ra; mem_ack = ack;
    #1;
  endtask

  task automatic model_check();
    int mi, fi, w;
    mi = (st_valid && merge_en) ? find_merge(st_addr[31:4]) : -1;
    chk(st_stall == (st_valid && mi < 0 && q_n == 4), "R5 stall", st_stall,
        st_valid && mi < 0 && q_n == 4);
    w  = int'(rd_addr[3:2]);
    fi = rd_valid ? find_word(rd_addr[31:4], w) : -1;
    chk(rd_fwd == (fi >= 0), "R8 R9 forward flag", rd_fwd, fi >= 0);
    if (fi >= 0 && rd_fwd)
      chk(rd_data == q_dat[fi][w], "R8 forward data", rd_data, q_dat[fi][w]);
    chk(mem_req == m_req, "R6 request", mem_req, m_req);
    if (m_req && mem_req) begin
      chk(mem_addr == {q_tag[0], 4'b0}, "R2 drain address", mem_addr, {q_tag[0], 4'b0});
      chk(mem_mask == q_mask[0], {cur_tag, " drain mask"}, mem_mask, q_mask[0]);
      for (int k = 0; k < 4; k++)
        if (q_mask[0][k])
          chk(mem_data[k*32 +: 32] == q_dat[0][k], {cur_tag, " R10 drain word"},
              mem_data[k*32 +: 32], q_dat[0][k]);
    end
  endtask

  task automatic model_update();
    int mi, w, n0;
    bit fire;
    n0   = q_n;
    fire = m_req && mem_ack;
    w    = int'(st_addr[3:2]);
    mi   = (st_valid && merge_en) ? find_merge(st_addr[31:4]) : -1;
    if (st_valid) begin
      if (mi >= 0) begin
        q_dat[mi][w] = st_data;
        q_mask[mi][w] = 1'b1;
      end else if (q_n < 4) begin
        q_tag[q_n] = st_addr[31:4];
        q_mask[q_n] = 4'b0001 << w;
        q_dat[q_n][w] = st_data;
        q_n++;
      end
    end
    if (fire) begin
      for (int i = 0; i < 3; i++) begin
        q_tag[i] = q_tag[i+1];
        q_mask[i] = q_mask[i+1];
        for (int k = 0; k < 4; k++) q_dat[i][k] = q_dat[i+1][k];
      end
      q_n--;
    end
    if (!m_req && n0 > 0) m_req = 1;
    else if (fire) m_req = 0;
  endtask

  task automatic finish_cycle();
    @(posedge clk);
    model_update();
  endtask

  task automatic cyc(input logic sv, input logic [31:0] sa, input logic [31:0] sd,
                     input logic me, input logic rv, input logic [31:0] ra,
                     input logic ack);
    drive(sv, sa, sd, me, rv, ra, ack);
    model_check();
    finish_cycle();
  endtask

  task automatic idle(input logic ack);
    cyc(0, 0, 0, 1, 0, 0, ack);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 0; st_valid = 0; st_addr = 0; st_data = 0; merge_en = 1;
    rd_valid = 0; rd_addr = 0; mem_ack = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: empty after reset
    drive(0, 0, 0, 1, 1, mk_addr(1, 0, 0), 0);
    chk(mem_req == 0, "R1 no request", mem_req, 0);
    chk(rd_fwd == 0, "R1 no forward", rd_fwd, 0);
    chk(st_stall == 0, "R1 no stall", st_stall, 0);
    model_check();
    finish_cycle();

    // R3 / R7: merge before the request, new entry after it
    cur_tag = "R3 R7";
    cyc(1, mk_addr(1, 0, 1), 32'h11, 1, 0, 0, 0);
    cyc(1, mk_addr(1, 1, 2), 32'h22, 1, 0, 0, 0);
    cyc(1, mk_addr(1, 2, 0), 32'h33, 1, 0, 0, 0);
    cyc(1, mk_addr(2, 3, 0), 32'h44, 1, 0, 0, 0);
    cyc(1, mk_addr(2, 1, 3), 32'h55, 1, 0, 0, 0);
    drive(0, 0, 0, 1, 1, mk_addr(1, 2, 0), 0);
    chk(mem_addr == 32'h10, "R2 head address", mem_addr, 32'h10);
    chk(mem_mask == 4'b0011, "R3 head mask", mem_mask, 4'b0011);
    chk(rd_fwd && rd_data == 32'h33, "R8 forward from second entry", rd_data, 32'h33);
    model_check(); finish_cycle();
    cyc(1, mk_addr(1, 0, 0), 32'h66, 1, 0, 0, 0);
    drive(0, 0, 0, 1, 1, mk_addr(1, 0, 0), 0);
    chk(rd_fwd && rd_data == 32'h66, "R8 newest copy wins", rd_data, 32'h66);
    model_check(); finish_cycle();
    drive(0, 0, 0, 1, 1, mk_addr(2, 2, 0), 0);
    chk(rd_fwd == 0, "R9 other word of pending block", rd_fwd, 0);
    model_check(); finish_cycle();
    idle(1);
    drive(0, 0, 0, 1, 0, 0, 0);
    chk(mem_req == 0, "R6 gap after ack", mem_req, 0);
    model_check(); finish_cycle();
    drive(0, 0, 0, 1, 0, 0, 0);
    chk(mem_mask == 4'b0101, "R7 reopened block mask", mem_mask, 4'b0101);
    model_check(); finish_cycle();

    // R4 / R5: merging off, then fill and stall
    cur_tag = "R4 R5";
    cyc(1, mk_addr(3, 0, 0), 32'h77, 0, 0, 0, 0);
    cyc(1, mk_addr(3, 1, 0), 32'h88, 0, 0, 0, 0);
    drive(1, mk_addr(4, 0, 0), 32'h99, 1, 0, 0, 0);
    chk(st_stall == 1, "R5 stall when full", st_stall, 1);
    model_check(); finish_cycle();
    drive(1, mk_addr(2, 3, 0), 32'hAA, 1, 0, 0, 0);
    chk(st_stall == 0, "R5 merge avoids stall", st_stall, 0);
    model_check(); finish_cycle();
    cur_tag = "R10";
    cyc(1, mk_addr(2, 3, 0), 32'hBB, 1, 0, 0, 0);
    cur_tag = "R4 R10";
    repeat (12) idle(1);
    drive(0, 0, 0, 1, 0, 0, 0);
    chk(mem_req == 0, "R6 drained empty", mem_req, 0);
    model_check(); finish_cycle();

    // sweep over three blocks with random merging, reads and acks
    cur_tag = "R3 R4 R7 R10";
    lf = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] sa, ra;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      sa = mk_addr(int'(lf[3:2]) % 3, int'(lf[5:4]), int'(lf[7:6]));
      ra = mk_addr(int'(lf[9:8]) % 3, int'(lf[11:10]), int'(lf[13:12]));
      cyc(lf[14], sa, {lf[31:16], 16'(n)}, lf[15] | lf[16], lf[17],
          ra, lf[18] & lf[19]);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule